// File: doc/BRIEF.md
# Pad Interrupt Router

The router takes a wide bundle of pad inputs and forwards up to eight of them, each on its own interrupt channel, to a downstream interrupt controller. That controller accepts only active-high levels or rising edges. For each channel the router therefore chooses one pad and can invert it. It then brings the signal into the clock domain, optionally debounces it, and presents the result as a level or as a one-cycle pulse.

Software programs the router through four 32-bit words on a simple register port. The port has a word index, write data, a write enable and combinational read data. Word 0 holds the per-channel mode and invert bits. Words 1 and 2 hold the 8-bit pad selectors. Word 3 holds the 4-bit filter lengths. A selector that points past the pads actually present feeds a constant 0 into its channel, so the channel cannot raise a spurious request.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset all four words read 0 and, with every pad low, every irq_o bit is 0 (pad 0, level mode, no inversion, filter bypassed).
- R2: A write to word index 0..3 is captured on the clock edge where we_i is high, and that word then reads back exactly the 32 bits written.
- R3: Channel x takes its pad index from word 1 for x = 0..3 and from word 2 for x = 4..7, in bits [(x mod 4)*8 +: 8], and routes pads_i[index].
- R4: In word 0, bit x set puts channel x in edge mode, and bit 16+x set inverts the pad seen by channel x.
- R5: In edge mode a channel drives irq_o high for exactly one cycle each time its polarity-corrected, filtered signal goes from 0 to 1. The opposite transition produces nothing, so without inversion a falling pad is ignored and with inversion a rising pad is ignored.
- R6: In level mode irq_o follows the polarity-corrected signal. With the filter bypassed, a pad change driven before clock edge k shows at irq_o after edge k+1, because of the two-flop synchroniser.
- R7: Word 3 bits [x*4 +: 4] hold the filter length N of channel x. For N = 0 there is no filtering. For N > 0 the filtered value takes a new level only after that level has held for N*8 consecutive cycles, which adds N*8 cycles of latency and drops shorter pulses.
- R8: A pad index at or above NUM_PADS feeds 0 into the channel whatever its invert bit, so the channel's output stays low.
- R9: Channels are independent: each routes its own pad with its own settings, and several may select the same pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pads_i | input | NUM_PADS | Asynchronous pad inputs |
| addr_i | input | 2 | Register word index (byte offset / 4) |
| wdata_i | input | 32 | Register write data |
| we_i | input | 1 | Register write enable |
| rdata_o | output | 32 | Read data of the addressed word, combinational |
| irq_o | output | NUM_CH | Active-high interrupt request per channel |

## Verification
Many internal faults show at irq_o within two clock edges of the stimulus that exposes them. A corrupted selector field routes the wrong pad, and a stale synchroniser stage shifts the latency by one cycle. A wrong invert bit flips the output level. A filter counter that ends early or late moves the filtered transition away from edge k+1+N*8, and a pulse-shortening fault lets a short pulse through. An edge detector that keeps its history wrongly stretches a pulse past one cycle or fires on the opposite transition. A register fault shows on rdata_o on the cycle after the write.

// File: rtl/gim_pkg.sv
package gim_pkg;
  localparam int REG_W    = 32;
  localparam int NUM_REGS = 4;
  localparam int IDX_W    = $clog2(NUM_REGS);

  typedef enum logic [IDX_W-1:0] {
    WORD_MODE   = 2'd0,
    WORD_SEL_LO = 2'd1,
    WORD_SEL_HI = 2'd2,
    WORD_FILT   = 2'd3
  } word_e;

  localparam int INV_BASE = 16;  // invert bits start here in the mode word
  localparam int SEL_PER_WORD = 4;
endpackage

// File: rtl/gim_regs.sv
module gim_regs
  import gim_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 8,
  parameter int FLT_W  = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [IDX_W-1:0]                 addr_i,
  input  logic [REG_W-1:0]                 wdata_i,
  input  logic                             we_i,
  output logic [REG_W-1:0]                 rdata_o,
  output logic [NUM_CH-1:0]                edge_en_o,
  output logic [NUM_CH-1:0]                inv_o,
  output logic [NUM_CH-1:0][SEL_W-1:0]     sel_o,
  output logic [NUM_CH-1:0][FLT_W-1:0]     flt_o
);
  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   regs_q <= '0;
    else if (we_i) regs_q[addr_i] <= wdata_i;
  end

  assign rdata_o = regs_q[addr_i];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_fields
    localparam int SW = int'(WORD_SEL_LO) + ch / SEL_PER_WORD;
    localparam int SB = (ch % SEL_PER_WORD) * SEL_W;
    assign edge_en_o[ch] = regs_q[WORD_MODE][ch];
    assign inv_o[ch]     = regs_q[WORD_MODE][INV_BASE + ch];
    assign sel_o[ch]     = regs_q[SW][SB +: SEL_W];
    assign flt_o[ch]     = regs_q[WORD_FILT][ch*FLT_W +: FLT_W];
  end
endmodule

// File: rtl/gim_filter.sv
module gim_filter #(
  parameter int FLT_W    = 4,
  parameter int FLT_UNIT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  input  logic [FLT_W-1:0] cfg_i,
  output logic             q_o
);
  localparam int MAX_LEN = ((1 << FLT_W) - 1) * FLT_UNIT;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_c;
  logic             hold_q;
  logic             bypass;

  assign bypass = (cfg_i == '0);
  assign last_c = CNT_W'(32'(cfg_i) * FLT_UNIT - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else if (bypass || d_i == hold_q) begin
      cnt_q  <= '0;
      hold_q <= d_i;  // track while bypassed so enabling causes no glitch
    end else if (cnt_q == last_c) begin
      cnt_q  <= '0;
      hold_q <= d_i;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign q_o = bypass ? d_i : hold_q;
endmodule

// File: rtl/gim_channel.sv
module gim_channel #(
  parameter int NUM_PADS = 134,
  parameter int SEL_W    = 8,
  parameter int FLT_W    = 4,
  parameter int FLT_UNIT = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PADS-1:0] pads_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                inv_i,
  input  logic                edge_i,
  input  logic [FLT_W-1:0]    flt_i,
  output logic                irq_o,
  output logic                sel_bad_o,
  output logic                sync1_o,
  output logic                sync2_o,
  output logic                filt_o
);
  localparam int EXT = 1 << SEL_W;

  logic [EXT-1:0] pad_ext;
  logic           raw;
  logic           s1_q, s2_q, prev_q, filt;

  assign pad_ext   = EXT'(pads_i);
  assign sel_bad_o = (32'(sel_i) >= NUM_PADS);
  assign raw       = sel_bad_o ? 1'b0 : (pad_ext[sel_i] ^ inv_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      prev_q <= filt;
    end
  end

  gim_filter #(.FLT_W(FLT_W), .FLT_UNIT(FLT_UNIT)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (s2_q),
    .cfg_i (flt_i),
    .q_o   (filt)
  );

  assign irq_o   = edge_i ? (filt & ~prev_q) : filt;
  assign sync1_o = s1_q;
  assign sync2_o = s2_q;
  assign filt_o  = filt;
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
  import gim_pkg::*;
#(
  parameter int NUM_PADS = 134,
  parameter int NUM_CH   = 8,   // register layout holds at most 8
  parameter int SEL_W    = 8,
  parameter int FLT_W    = 4,
  parameter int FLT_UNIT = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PADS-1:0] pads_i,
  input  logic [1:0]          addr_i,
  input  logic [31:0]         wdata_i,
  input  logic                we_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_CH-1:0]   irq_o
);
  logic [NUM_CH-1:0]            edge_en, inv, sel_bad, sync1, sync2, filt;
  logic [NUM_CH-1:0][SEL_W-1:0] sel;
  logic [NUM_CH-1:0][FLT_W-1:0] flt_cfg;

  gim_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .FLT_W(FLT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .we_i     (we_i),
    .rdata_o  (rdata_o),
    .edge_en_o(edge_en),
    .inv_o    (inv),
    .sel_o    (sel),
    .flt_o    (flt_cfg)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    gim_channel #(
      .NUM_PADS(NUM_PADS), .SEL_W(SEL_W), .FLT_W(FLT_W), .FLT_UNIT(FLT_UNIT)
    ) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pads_i   (pads_i),
      .sel_i    (sel[ch]),
      .inv_i    (inv[ch]),
      .edge_i   (edge_en[ch]),
      .flt_i    (flt_cfg[ch]),
      .irq_o    (irq_o[ch]),
      .sel_bad_o(sel_bad[ch]),
      .sync1_o  (sync1[ch]),
      .sync2_o  (sync2[ch]),
      .filt_o   (filt[ch])
    );
  end
endmodule

// File: rtl/gpio_irq_mux_chk.sv
module gpio_irq_mux_chk #(
  parameter int NUM_CH = 8,
  parameter int FLT_W  = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [1:0]                     addr_i,
  input logic [31:0]                    wdata_i,
  input logic                           we_i,
  input logic [31:0]                    rdata_o,
  input logic [NUM_CH-1:0]              irq_o,
  input logic [NUM_CH-1:0]              edge_en,
  input logic [NUM_CH-1:0]              sel_bad,
  input logic [NUM_CH-1:0]              sync1,
  input logic [NUM_CH-1:0]              sync2,
  input logic [NUM_CH-1:0]              filt,
  input logic [NUM_CH-1:0][FLT_W-1:0]   flt_cfg
);
  assert_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && addr_i == $past(addr_i)) |-> rdata_o == $past(wdata_i));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    assert_pulse_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_en[i] && irq_o[i]) |=> !(edge_en[i] && irq_o[i]));

    assert_bad_sel_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_bad[i] |=> !sync1[i]);

    assert_filter_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flt_cfg[i] != '0 && flt_cfg[i] == $past(flt_cfg[i]) && filt[i] != $past(filt[i]))
        |-> filt[i] == $past(sync2[i]));
  end
endmodule

bind gpio_irq_mux gpio_irq_mux_chk #(.NUM_CH(NUM_CH), .FLT_W(FLT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .we_i   (we_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .edge_en(edge_en),
  .sel_bad(sel_bad),
  .sync1  (sync1),
  .sync2  (sync2),
  .filt   (filt),
  .flt_cfg(flt_cfg)
);

// File: tb/gpio_irq_mux_test.sv
module gpio_irq_mux_test;
  localparam int NP = 134;
  localparam int NC = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pads_i = '0;
  logic [1:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic          we_i = 1'b0;
  logic [31:0]   rdata_o;
  logic [NC-1:0] irq_o;

  int  n_vec = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  gpio_irq_mux uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pads_i(pads_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    tick();
    we_i = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    check(tag, rdata_o, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    ticks(3);
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    for (int a = 0; a < 4; a++) rd("R1 reset word", 2'(a), 32'h0);
    check("R1 reset irq", 32'(irq_o), 32'h0);

    // R2 readback
    wr(2'd0, 32'hA5C3_0F96); wr(2'd1, 32'h1234_5678);
    wr(2'd2, 32'hFEDC_BA98); wr(2'd3, 32'h0BAD_F00D);
    rd("R2 word0", 2'd0, 32'hA5C3_0F96);
    rd("R2 word1", 2'd1, 32'h1234_5678);
    rd("R2 word2", 2'd2, 32'hFEDC_BA98);
    rd("R2 word3", 2'd3, 32'h0BAD_F00D);
    for (int a = 0; a < 4; a++) wr(2'(a), 32'h0);

    // R3/R8 sweep every selector value on channel 0, pads[i] = (i%3==0)
    for (int i = 0; i < NP; i++) pads_i[i] = (i % 3 == 0);
    for (int s = 0; s < 256; s++) begin
      wr(2'd1, 32'(s));
      ticks(2);
      check("R3 R8 ch0 select", 32'(irq_o[0]), 32'((s < NP) && (s % 3 == 0)));
    end
    // R4/R8 same sweep with channel 0 inverted
    wr(2'd0, 32'h0001_0000);
    for (int s = 0; s < 256; s++) begin
      wr(2'd1, 32'(s));
      ticks(2);
      check("R4 R8 ch0 inverted select", 32'(irq_o[0]), 32'((s < NP) && (s % 3 != 0)));
    end
    wr(2'd0, 32'h0);
    // R3 channel 5 lives in word 2 bits [15:8]
    for (int s = 0; s < 256; s++) begin
      wr(2'd2, 32'(s) << 8);
      ticks(2);
      check("R3 ch5 select", 32'(irq_o[5]), 32'((s < NP) && (s % 3 == 0)));
    end

    // R9 independent channels: channel x selects pad 10+x
    pads_i = '0;
    wr(2'd1, 32'h0D0C_0B0A);
    wr(2'd2, 32'h1110_0F0E);
    for (int j = 0; j < NC; j++) begin
      pads_i = '0;
      pads_i[10 + j] = 1'b1;
      ticks(2);
      check("R9 one pad one channel", 32'(irq_o), 32'(1) << j);
    end
    pads_i = '0;
    ticks(2);
    wr(2'd0, 32'h1 << (16 + 5));
    ticks(2);
    check("R4 ch5 invert bit", 32'(irq_o), 32'h20);
    // R9 all channels on one pad
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h1414_1414);
    wr(2'd2, 32'h1414_1414);
    pads_i[20] = 1'b1;
    ticks(2);
    check("R9 shared pad", 32'(irq_o), 32'hFF);
    pads_i = '0;
    wr(2'd1, 32'h0000_0014);
    wr(2'd2, 32'h0);
    ticks(3);

    // R6 level latency: visible after the second edge
    pads_i[20] = 1'b1;
    tick();
    check("R6 latency one edge", 32'(irq_o[0]), 32'h0);
    tick();
    check("R6 latency two edges", 32'(irq_o[0]), 32'h1);
    pads_i[20] = 1'b0;
    ticks(2);
    check("R6 level drops", 32'(irq_o[0]), 32'h0);

    // R5 edge mode, rising pad
    wr(2'd0, 32'h1);
    ticks(3);
    check("R5 idle", 32'(irq_o[0]), 32'h0);
    pads_i[20] = 1'b1;
    tick();
    check("R5 before pulse", 32'(irq_o[0]), 32'h0);
    tick();
    check("R5 pulse", 32'(irq_o[0]), 32'h1);
    tick();
    check("R5 pulse one cycle", 32'(irq_o[0]), 32'h0);
    tick();
    check("R5 no repeat", 32'(irq_o[0]), 32'h0);
    pads_i[20] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R5 falling ignored", 32'(irq_o[0]), 32'h0);
    end
    // R5 edge mode inverted: falling pad pulses, rising ignored
    pads_i[20] = 1'b1;
    wr(2'd0, 32'h0001_0001);
    ticks(4);
    pads_i[20] = 1'b0;
    tick();
    check("R5 inv before pulse", 32'(irq_o[0]), 32'h0);
    tick();
    check("R5 inv pulse on fall", 32'(irq_o[0]), 32'h1);
    tick();
    check("R5 inv pulse one cycle", 32'(irq_o[0]), 32'h0);
    pads_i[20] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R5 inv rising ignored", 32'(irq_o[0]), 32'h0);
    end

    // R7 filter N=2 on channel 0, level mode
    pads_i[20] = 1'b0;
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h2);
    ticks(40);
    check("R7 filter idle", 32'(irq_o[0]), 32'h0);
    pads_i[20] = 1'b1;
    ticks(1 + 16);
    check("R7 N=2 one edge early", 32'(irq_o[0]), 32'h0);
    tick();
    check("R7 N=2 on time", 32'(irq_o[0]), 32'h1);
    pads_i[20] = 1'b0;
    ticks(10);
    pads_i[20] = 1'b1;
    begin
      bit low_seen = 1'b0;
      for (int k = 0; k < 30; k++) begin
        tick();
        if (irq_o[0] !== 1'b1) low_seen = 1'b1;
      end
      check("R7 short low pulse dropped", 32'(low_seen), 32'h0);
    end
    // R7 channel 3 with N=15 (field bits [15:12])
    pads_i[20] = 1'b0;
    wr(2'd1, 32'h1400_0000);
    wr(2'd3, 32'h0000_F000);
    ticks(150);
    check("R7 ch3 idle", 32'(irq_o[3]), 32'h0);
    pads_i[20] = 1'b1;
    ticks(1 + 120);
    check("R7 N=15 one edge early", 32'(irq_o[3]), 32'h0);
    tick();
    check("R7 N=15 on time", 32'(irq_o[3]), 32'h1);
    // R7 bypass restored: N=0
    wr(2'd3, 32'h0);
    pads_i[20] = 1'b0;
    ticks(2);
    check("R7 bypass", 32'(irq_o[3]), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule